// File: doc/BRIEF.md
# Buffered Program Staging Unit

This block gathers the data of one buffered flash-program sequence in a 128-byte staging area and then commits it to a small internal byte array that stands in for the flash cells. A sequence begins with a start strobe, which clears the staging area and forgets any earlier base address. A length strobe then sets how many bytes the host intends to send. Addressed data writes follow, each carrying 1, 2 or 4 bytes.

The first data write fixes the window base. Each later write lands at its distance from that base, provided it falls inside the window and the byte budget is not used up. A write that cannot be accepted ends the sequence. If its low data byte is the confirm code, the collected bytes are copied into the array one byte per clock, unless the lock block holding the base is protected. Any other rejected write aborts with an error flag. A read port lets the array contents be observed.

Top module: `fwb_capture`

## Requirements
- R1: After reset the error status is 0x00, `done` and `busy` are low, and every array byte reads 0xFF.
- R2: A length strobe with value v sets the byte budget to (v+1)*4 bytes, limited to 128. It only takes effect after a start strobe.
- R3: The first data write after the length strobe becomes the window base. A write at address a stores data byte k, little-endian, at staging offset (a - base + k).
- R4: A write whose address is below the base is rejected and its bytes are not stored.
- R5: A write whose offset from the base is 128 or more is rejected and its bytes are not stored.
- R6: A write is rejected once the written byte count has reached the budget. Each accepted write adds its byte count (1, 2 or 4) to the written count.
- R7: A rejected write whose data bits [7:0] equal 0xD0 is a confirm. It copies staging offsets 0 to count-1 into the array at base onwards.
- R8: A rejected write with any other low byte sets status bit 4 (0x10), ends the sequence without a `done` pulse, and leaves the array unchanged. Status bits stay set until reset.
- R9: On confirm, if `lock_mask[base / 64]` is 1, the array is left unchanged, status bits 4 and 1 (0x12) are set, and `done` pulses in the cycle after the confirm.
- R10: An unlocked commit holds `busy` for one clock per byte and ends with a one-cycle `done` pulse. The `done` pulse comes count cycles after the confirm edge. Writes and start strobes are ignored while `busy` is high.
- R11: A start strobe clears the whole staging area to zero. Offsets below the count that no write reached are committed as 0x00.
- R12: Data writes and length strobes outside a sequence have no effect on the array or the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_start | input | 1 | Begin a new buffered sequence |
| len_ld | input | 1 | Load byte budget from `len_val` |
| len_val | input | 8 | Budget word, (v+1)*4 bytes |
| wr_en | input | 1 | Data write strobe |
| wr_addr | input | 9 | Byte address of the write |
| wr_data | input | 32 | Write data, byte 0 in bits [7:0] |
| wr_bytes | input | 3 | Bytes in this write: 1, 2 or 4 |
| lock_mask | input | 8 | One protect bit per 64-byte block |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| err_sts | output | 8 | Sticky error flags, bits 4 and 1 |
| busy | output | 1 | Commit copy in progress |
| done | output | 1 | One-cycle end-of-commit pulse |

## Verification
The assertions watch, on every cycle, the sequencing around the end of a sequence. A confirm either starts a copy or raises both lock flags with a `done` pulse. An abort raises bit 4 with no pulse. `done` never lasts two cycles, and the end of `busy` always coincides with `done`. They also check that nothing is accepted during a copy, that error flags never drop, and that the written count stays within a word of the budget. Only the bench scenarios can show that bytes land at the right offsets. The same holds for cleared offsets committing as zero, out-of-window or below-base data being kept out of the array, and the copy length matching the byte count.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef enum logic [1:0] {
    FWB_IDLE,
    FWB_LEN,
    FWB_FILL,
    FWB_COPY
  } fwb_state_e;

  localparam logic [7:0] FWB_CONFIRM  = 8'hD0;
  localparam logic [7:0] FWB_ST_ABORT = 8'h10;
  localparam logic [7:0] FWB_ST_LOCK  = 8'h12;

  // byte budget from the length word: (v+1) words of four bytes, capped
  function automatic int unsigned fwb_len_bytes(input logic [7:0] v,
                                                input int unsigned cap);
    int unsigned n;
    n = (int'(v) + 1) * 4;
    return (n > cap) ? cap : n;
  endfunction

  // true when byte k of a write starting at offset off stays inside the buffer
  function automatic logic fwb_lane_fits(input int unsigned off,
                                         input int unsigned k,
                                         input int unsigned cap);
    return (off + k) < cap;
  endfunction

endpackage

// File: rtl/fwb_stage.sv
module fwb_stage #(
  parameter int BUF_BYTES = 128,
  localparam int BOFF_W = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [BOFF_W-1:0] woff,
  input  logic [31:0]       wdata,
  input  logic [2:0]        wbytes,
  input  logic [BOFF_W-1:0] ridx,
  output logic [7:0]        rbyte
);
  import fwb_pkg::*;

  logic [7:0] mem_q [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= 8'h00;
    end else if (we) begin
      for (int k = 0; k < 4; k++) begin
        if ((3'(k) < wbytes) &&
            fwb_lane_fits(int'(woff), k, BUF_BYTES)) begin
          mem_q[woff + BOFF_W'(k)] <= wdata[8*k +: 8];
        end
      end
    end
  end

  assign rbyte = mem_q[ridx];

endmodule

// File: rtl/fwb_array.sv
module fwb_array #(
  parameter int ARR_BYTES = 512,
  localparam int ADDR_W = $clog2(ARR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wbyte,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rbyte
);

  logic [7:0] cell_q [ARR_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_BYTES; i++) cell_q[i] <= 8'hFF;
    end else if (we) begin
      cell_q[waddr] <= wbyte;
    end
  end

  assign rbyte = cell_q[raddr];

endmodule

// File: rtl/fwb_ctrl.sv
module fwb_ctrl #(
  parameter int ADDR_W    = 9,
  parameter int BUF_BYTES = 128,
  parameter int BLK_BYTES = 64,
  parameter int NUM_BLKS  = 8,
  localparam int BOFF_W = $clog2(BUF_BYTES),
  localparam int CNT_W  = BOFF_W + 1,
  localparam int BLK_SH = $clog2(BLK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start,
  input  logic              len_ld,
  input  logic [7:0]        len_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_cmd,
  input  logic [2:0]        wr_bytes,
  input  logic [NUM_BLKS-1:0] lock_mask,
  output logic              buf_clr,
  output logic              acc_evt,
  output logic [BOFF_W-1:0] acc_off,
  output logic              cfm_evt,
  output logic              abort_evt,
  output logic              lock_hit,
  output logic              copy_we,
  output logic [BOFF_W-1:0] copy_idx,
  output logic [ADDR_W-1:0] copy_addr,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic [CNT_W-1:0]  exp_len,
  output logic              busy,
  output logic              done,
  output logic [7:0]        err_sts
);
  import fwb_pkg::*;

  fwb_state_e        st_q;
  logic [ADDR_W-1:0] base_q;
  logic              base_ok_q;
  logic [CNT_W-1:0]  cnt_q, exp_q, idx_q;
  logic [7:0]        sts_q;
  logic              done_q;

  logic [ADDR_W-1:0] base_eff, off_full;
  logic              below, off_out, full, in_fill, rej, last_copy;

  always_comb begin
    base_eff = base_ok_q ? base_q : wr_addr;
    off_full = wr_addr - base_eff;
    below    = base_ok_q && (wr_addr < base_q);
    off_out  = {1'b0, off_full} >= (ADDR_W+1)'(BUF_BYTES);
    full     = cnt_q >= exp_q;
    in_fill  = (st_q == FWB_FILL) && wr_en;
    acc_evt  = in_fill && !below && !off_out && !full;
    rej      = in_fill && !acc_evt;
    cfm_evt  = rej && (wr_cmd == FWB_CONFIRM);
    abort_evt = rej && !cfm_evt;
    lock_hit = 1'b0;
    for (int i = 0; i < NUM_BLKS; i++) begin
      if (int'(base_q >> BLK_SH) == i) lock_hit = lock_mask[i];
    end
  end

  assign acc_off   = off_full[BOFF_W-1:0];
  assign busy      = (st_q == FWB_COPY);
  assign buf_clr   = seq_start && !busy;
  assign copy_we   = busy;
  assign copy_idx  = idx_q[BOFF_W-1:0];
  assign copy_addr = base_q + ADDR_W'(idx_q);
  assign last_copy = busy && (idx_q == cnt_q - CNT_W'(1));
  assign wr_cnt    = cnt_q;
  assign exp_len   = exp_q;
  assign done      = done_q;
  assign err_sts   = sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= FWB_IDLE;
      base_q    <= '0;
      base_ok_q <= 1'b0;
      cnt_q     <= '0;
      exp_q     <= '0;
      idx_q     <= '0;
      sts_q     <= 8'h00;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (buf_clr) begin
        st_q      <= FWB_LEN;
        base_ok_q <= 1'b0;
        cnt_q     <= '0;
      end else begin
        case (st_q)
          FWB_LEN: begin
            if (len_ld) begin
              exp_q <= CNT_W'(fwb_len_bytes(len_val, BUF_BYTES));
              st_q  <= FWB_FILL;
            end
          end
          FWB_FILL: begin
            if (acc_evt) begin
              if (!base_ok_q) begin
                base_q    <= wr_addr;
                base_ok_q <= 1'b1;
              end
              cnt_q <= cnt_q + CNT_W'(wr_bytes);
            end else if (cfm_evt) begin
              if (lock_hit) begin
                sts_q  <= sts_q | FWB_ST_LOCK;
                st_q   <= FWB_IDLE;
                done_q <= 1'b1;
              end else begin
                st_q  <= FWB_COPY;
                idx_q <= '0;
              end
            end else if (abort_evt) begin
              sts_q <= sts_q | FWB_ST_ABORT;
              st_q  <= FWB_IDLE;
            end
          end
          FWB_COPY: begin
            idx_q <= idx_q + CNT_W'(1);
            if (last_copy) begin
              st_q   <= FWB_IDLE;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/fwb_capture.sv
module fwb_capture #(
  parameter int ARR_BYTES = 512,
  parameter int BLK_BYTES = 64,
  parameter int BUF_BYTES = 128,
  localparam int ADDR_W   = $clog2(ARR_BYTES),
  localparam int NUM_BLKS = ARR_BYTES / BLK_BYTES,
  localparam int BOFF_W   = $clog2(BUF_BYTES),
  localparam int CNT_W    = BOFF_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                seq_start,
  input  logic                len_ld,
  input  logic [7:0]          len_val,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [2:0]          wr_bytes,
  input  logic [NUM_BLKS-1:0] lock_mask,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [7:0]          rd_data,
  output logic [7:0]          err_sts,
  output logic                busy,
  output logic                done
);

  logic              buf_clr, acc_evt, cfm_evt, abort_evt, lock_hit, copy_we;
  logic [BOFF_W-1:0] acc_off, copy_idx;
  logic [ADDR_W-1:0] copy_addr;
  logic [CNT_W-1:0]  wr_cnt, exp_len;
  logic [7:0]        stage_byte;

  fwb_ctrl #(
    .ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES),
    .BLK_BYTES(BLK_BYTES), .NUM_BLKS(NUM_BLKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start),
    .len_ld(len_ld), .len_val(len_val),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_cmd(wr_data[7:0]),
    .wr_bytes(wr_bytes), .lock_mask(lock_mask),
    .buf_clr(buf_clr), .acc_evt(acc_evt), .acc_off(acc_off),
    .cfm_evt(cfm_evt), .abort_evt(abort_evt), .lock_hit(lock_hit),
    .copy_we(copy_we), .copy_idx(copy_idx), .copy_addr(copy_addr),
    .wr_cnt(wr_cnt), .exp_len(exp_len),
    .busy(busy), .done(done), .err_sts(err_sts)
  );

  fwb_stage #(.BUF_BYTES(BUF_BYTES)) u_stage (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .we(acc_evt), .woff(acc_off), .wdata(wr_data), .wbytes(wr_bytes),
    .ridx(copy_idx), .rbyte(stage_byte)
  );

  fwb_array #(.ARR_BYTES(ARR_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we(copy_we), .waddr(copy_addr), .wbyte(stage_byte),
    .raddr(rd_addr), .rbyte(rd_data)
  );

endmodule

// File: rtl/fwb_capture_chk.sv
module fwb_capture_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             busy,
  input logic [7:0]       err_sts,
  input logic             acc_evt,
  input logic             cfm_evt,
  input logic             abort_evt,
  input logic             lock_hit,
  input logic [CNT_W-1:0] wr_cnt,
  input logic [CNT_W-1:0] exp_len
);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_evt);

  p_copy_end_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_unlocked_starts_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfm_evt && !lock_hit) |=> busy);

  p_locked_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfm_evt && lock_hit) |=> (err_sts[1] && err_sts[4] && done && !busy));

  p_abort_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (err_sts[4] && !busy && !done));

  p_sts_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err_sts[4]) && !$fell(err_sts[1]));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_cnt) <= int'(exp_len) + 3);

endmodule

bind fwb_capture fwb_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .err_sts(err_sts),
  .acc_evt(acc_evt), .cfm_evt(cfm_evt), .abort_evt(abort_evt),
  .lock_hit(lock_hit), .wr_cnt(wr_cnt), .exp_len(exp_len)
);

// File: tb/sim_fwb_capture.sv
`timescale 1ns/1ps
module sim_fwb_capture;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seq_start = 1'b0, len_ld = 1'b0, wr_en = 1'b0;
  logic [7:0] len_val = '0;
  logic [8:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] wr_bytes = 3'd4;
  logic [7:0] lock_mask = '0;
  logic [7:0] rd_data, err_sts;
  logic       busy, done;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  fwb_capture u0 (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .len_ld(len_ld),
    .len_val(len_val), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bytes(wr_bytes), .lock_mask(lock_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .err_sts(err_sts), .busy(busy), .done(done)
  );

  // {len word, base address, lock mask}
  localparam logic [24:0] VEC [7] = '{
    {8'd0,   9'h000, 8'h00},
    {8'd3,   9'h044, 8'h00},
    {8'd7,   9'h100, 8'h01},
    {8'd255, 9'h180, 8'h3F},
    {8'd1,   9'h0C0, 8'h08},
    {8'd2,   9'h010, 8'hFE},
    {8'd40,  9'h140, 8'h20}
  };

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] word_at(input int a);
    return {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start_seq();
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic load_len(input logic [7:0] v);
    len_ld = 1'b1; len_val = v;
    @(negedge clk);
    len_ld = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [2:0] b);
    wr_en = 1'b1; wr_addr = 9'(a); wr_data = d; wr_bytes = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] b);
    rd_addr = 9'(a);
    #0.5;
    b = rd_data;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic chk_byte(input int a, input logic [7:0] e, input string req);
    logic [7:0] b;
    rd(a, b);
    chk(b == e, req, b, e);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog timeout actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    int seen;
    logic [7:0] b;
    @(negedge clk);
    do_reset();

    // R1: reset state
    chk(err_sts == 8'h00, "R1 status", err_sts, 0);
    chk(!done && !busy, "R1 done/busy", {done, busy}, 0);
    chk_byte(5, 8'hFF, "R1 array erased");

    // table walk: R2, R3, R7, R9, R10
    for (int v = 0; v < 7; v++) begin
      int len, base, nw, exp_b, locked, bad, bad_at;
      len = int'(VEC[v][24:17]);
      base = int'(VEC[v][16:8]);
      exp_b = (len + 1) * 4;
      if (exp_b > 128) exp_b = 128;
      nw = exp_b / 4;
      locked = int'(VEC[v][7:0] >> (base / 64)) & 1;
      do_reset();
      lock_mask = VEC[v][7:0];
      start_seq();
      load_len(8'(len));
      for (int w = 0; w < nw; w++) wr(base + 4 * w, word_at(base + 4 * w), 3'd4);
      wr(base, 32'h000000D0, 3'd4);
      wait_done(cyc);
      chk(cyc == (locked ? 0 : exp_b), "R10/R2 commit cycles", cyc, locked ? 0 : exp_b);
      chk(err_sts == (locked ? 8'h12 : 8'h00), "R9/R7 status", err_sts, locked ? 8'h12 : 8'h00);
      @(negedge clk);
      chk(!done, "R10 done one cycle", done, 0);
      bad = 0; bad_at = 0;
      for (int i = 0; i < exp_b; i++) begin
        rd(base + i, b);
        if (b !== (locked ? 8'hFF : pat(base + i))) begin
          if (bad == 0) bad_at = base + i;
          bad++;
        end
      end
      chk(bad == 0, locked ? "R9 locked array unchanged" : "R7/R3 array contents", bad_at, 0);
      if (base + exp_b < 512) chk_byte(base + exp_b, 8'hFF, "R2 beyond budget untouched");
    end
    lock_mask = '0;

    // R11 + R3: gap offsets commit as zero
    do_reset();
    start_seq(); load_len(8'd1);
    wr(9'h020, 32'h44332211, 3'd4);
    wr(9'h028, 32'h88776655, 3'd4);
    wr(9'h020, 32'h000000D0, 3'd4);
    wait_done(cyc);
    chk(cyc == 8, "R11 commit cycles", cyc, 8);
    chk_byte(9'h020, 8'h11, "R3 first byte");
    chk_byte(9'h023, 8'h44, "R3 last byte of first word");
    chk_byte(9'h024, 8'h00, "R11 cleared offset");
    chk_byte(9'h027, 8'h00, "R11 cleared offset end");
    chk_byte(9'h028, 8'hFF, "R11 beyond count");

    // R4: below-base write rejected and acts as confirm
    do_reset();
    start_seq(); load_len(8'd1);
    wr(9'h040, 32'hA1A2A3A4, 3'd4);
    wr(9'h03C, 32'h000000D0, 3'd4);
    wait_done(cyc);
    chk(cyc == 4, "R4 commit cycles", cyc, 4);
    chk_byte(9'h03C, 8'hFF, "R4 below base not stored");
    chk_byte(9'h040, 8'hA4, "R4 base byte");
    chk_byte(9'h044, 8'hFF, "R4 after count");

    // R5: offset 128 rejected
    do_reset();
    start_seq(); load_len(8'd255);
    wr(9'h000, 32'h0D0C0B0A, 3'd4);
    wr(9'h080, 32'h000000D0, 3'd4);
    wait_done(cyc);
    chk(cyc == 4, "R5 commit cycles", cyc, 4);
    chk_byte(9'h080, 8'hFF, "R5 out of window not stored");
    chk_byte(9'h000, 8'h0A, "R5 base byte");
    chk(err_sts == 8'h00, "R5 status", err_sts, 0);

    // R6: byte counts 1,1,2 fill a 4-byte budget
    do_reset();
    start_seq(); load_len(8'd0);
    wr(9'h100, 32'h999999AA, 3'd1);
    wr(9'h101, 32'h999999BB, 3'd1);
    wr(9'h102, 32'h9999DDCC, 3'd2);
    wr(9'h103, 32'h000000D0, 3'd1);
    wait_done(cyc);
    chk(err_sts == 8'h00, "R6 status", err_sts, 0);
    chk(cyc == 4, "R6 commit cycles", cyc, 4);
    chk_byte(9'h100, 8'hAA, "R6 byte 0");
    chk_byte(9'h101, 8'hBB, "R6 byte 1");
    chk_byte(9'h103, 8'hDD, "R6 byte 3");
    chk_byte(9'h104, 8'hFF, "R6 after count");

    // R8: non-confirm rejection aborts
    do_reset();
    start_seq(); load_len(8'd0);
    wr(9'h000, 32'h01020304, 3'd4);
    wr(9'h004, 32'h00000011, 3'd4);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (done || busy) seen++;
      @(negedge clk);
    end
    chk(err_sts == 8'h10, "R8 abort status", err_sts, 8'h10);
    chk(seen == 0, "R8 no done or busy", seen, 0);
    chk_byte(9'h000, 8'hFF, "R8 array unchanged");

    // R12: writes outside a sequence ignored
    do_reset();
    wr(9'h000, 32'h000000D0, 3'd4);
    load_len(8'd0);
    wr(9'h004, 32'h00000055, 3'd4);
    wr(9'h008, 32'h00000066, 3'd4);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      if (done || busy) seen++;
      @(negedge clk);
    end
    chk(err_sts == 8'h00 && seen == 0, "R12 idle ignore status", err_sts, 0);
    chk_byte(9'h004, 8'hFF, "R12 array untouched");

    // R10: start and writes during copy ignored
    do_reset();
    start_seq(); load_len(8'd255);
    for (int w = 0; w < 32; w++) wr(4 * w, word_at(4 * w), 3'd4);
    wr(9'h000, 32'h000000D0, 3'd4);
    chk(busy == 1'b1, "R10 busy during copy", busy, 1);
    seq_start = 1'b1; wr_en = 1'b1; wr_addr = 9'h000; wr_data = 32'h77777777; wr_bytes = 3'd4;
    @(negedge clk);
    seq_start = 1'b0; wr_en = 1'b0;
    wait_done(cyc);
    chk(cyc + 1 == 128, "R10 full commit cycles", cyc + 1, 128);
    @(negedge clk);
    chk(!done && !busy, "R10 idle after done", {done, busy}, 0);
    chk_byte(9'h000, pat(0), "R10 copy unaffected");
    chk_byte(9'h07F, pat(127), "R10 last byte");
    load_len(8'd0);
    wr(9'h000, 32'h00000011, 3'd4);
    wr(9'h004, 32'h00000011, 3'd4);
    chk(err_sts == 8'h00, "R10 start during busy ignored", err_sts, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule